// File: doc/BRIEF.md
# Cross-Port Mailbox Word Memory

This block is a synchronous memory with two independent ports, A and B, each able to read or write any 16-bit word on every clock. Writes are masked per byte lane by an upper select and a lower select. Reads are registered, so data appears one cycle after the request. A lane that was not selected reads as zero.

The two highest words also act as mailboxes for passing messages between the ports. The highest word belongs to port B and the word just below it belongs to port A. When one port writes the other port's mailbox, it raises that port's interrupt, which is an active-low output. The interrupt stays low until its owner reads its own mailbox. Each port has a busy input, driven by arbitration logic outside this block. While a port's busy is high, its mailbox write does not raise an interrupt and its mailbox read does not clear one. The busy input has no effect on ordinary data storage. The depth is set by the address-width parameter.

Top module: `xport_mailbox_ram`

## Requirements
- R1: After reset both interrupt outputs are high (inactive) and both read-data outputs are zero.
- R2: A write happens when chip enable and write enable are high. The upper select (lane 1) writes bits 15:8 and the lower select (lane 0) writes bits 7:0. A lane that is not selected keeps its stored value.
- R3: A read happens when chip enable and output enable are high and write enable is low. Read data appears on the port in the cycle after the request. Each selected lane returns the stored byte and each unselected lane returns zero. In any cycle after a non-read, read data is zero.
- R4: A port with chip enable low, or with both byte selects low, does not access the memory: storage is unchanged and read data is zero.
- R5: A port-A write to address DEPTH-1 drives bIrqN low in the next cycle. A port-B write to address DEPTH-2 drives aIrqN low in the next cycle.
- R6: A port-B read of address DEPTH-1 returns bIrqN high in the next cycle. A port-A read of address DEPTH-2 returns aIrqN high in the next cycle.
- R7: A port reading the other port's mailbox changes neither interrupt.
- R8: While a port's busy input is high, its mailbox write sets no interrupt and its own mailbox read clears none. The data is still written or read.
- R9: If an interrupt is set and cleared in the same cycle, it ends up set (low).
- R10: When both ports write the same lane of the same address in one cycle, port A's byte is stored. A read of an address that the other port writes in the same cycle returns the old word.
- R11: Mailbox words are ordinary storage: the message written can be read back by either port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| aCe | input | 1 | Port A chip enable, active high |
| aWe | input | 1 | Port A write enable, active high |
| aOe | input | 1 | Port A output enable, active high |
| aUpper | input | 1 | Port A upper byte select |
| aLower | input | 1 | Port A lower byte select |
| aAddr | input | ADDR_W | Port A word address |
| aWrData | input | 16 | Port A write data |
| aBusy | input | 1 | Port A busy, suppresses its mailbox effects |
| aRdData | output | 16 | Port A registered read data |
| aIrqN | output | 1 | Port A interrupt, active low |
| bCe | input | 1 | Port B chip enable, active high |
| bWe | input | 1 | Port B write enable, active high |
| bOe | input | 1 | Port B output enable, active high |
| bUpper | input | 1 | Port B upper byte select |
| bLower | input | 1 | Port B lower byte select |
| bAddr | input | ADDR_W | Port B word address |
| bWrData | input | 16 | Port B write data |
| bBusy | input | 1 | Port B busy, suppresses its mailbox effects |
| bRdData | output | 16 | Port B registered read data |
| bIrqN | output | 1 | Port B interrupt, active low |

## Verification
The bench sweeps a 16-word instance. It fills every word from one port and reads it back from the other under every combination of byte selects. A design with swapped lanes, or one that drives stale data on unselected lanes, would return wrong bytes. Each mailbox is driven through the full sequence of set, peek by the other port, read under busy and owner read. A design that swapped the two mailbox addresses, let a peek clear the flag or ignored busy would show the wrong interrupt level one cycle later. The bench also checks a set and a clear in the same cycle, and two writes to the same word in the same cycle. A design that let the clear win, or gave port B priority, would keep the wrong value.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int WORD_W = 16;
  localparam int LANE_W = 8;
  localparam int LANE_N = WORD_W / LANE_W;

  typedef struct packed {
    logic [LANE_N-1:0] aWr;
    logic [LANE_N-1:0] aRd;
    logic [LANE_N-1:0] bWr;
    logic [LANE_N-1:0] bRd;
  } strobes_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aCe,
  input  logic              aWe,
  input  logic              aOe,
  input  logic              aUpper,
  input  logic              aLower,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic              aBusy,
  input  logic              bCe,
  input  logic              bWe,
  input  logic              bOe,
  input  logic              bUpper,
  input  logic              bLower,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic              bBusy,
  output strobes_t          strobes,
  output logic              aFlag,
  output logic              bFlag
);
  localparam logic [ADDR_W-1:0] BOX_B = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_A = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic [LANE_N-1:0] aLanes, bLanes;
  logic aAcc, bAcc, aWrite, bWrite, aRead, bRead;
  logic setA, setB, clrA, clrB;

  assign aLanes = {aUpper, aLower};
  assign bLanes = {bUpper, bLower};
  assign aAcc   = aCe && (|aLanes);
  assign bAcc   = bCe && (|bLanes);
  assign aWrite = aAcc && aWe;
  assign bWrite = bAcc && bWe;
  assign aRead  = aAcc && !aWe && aOe;
  assign bRead  = bAcc && !bWe && bOe;

  always_comb begin
    strobes     = '0;
    strobes.aWr = aWrite ? aLanes : '0;
    strobes.aRd = aRead  ? aLanes : '0;
    strobes.bWr = bWrite ? bLanes : '0;
    strobes.bRd = bRead  ? bLanes : '0;
  end

  // mailbox effects, each gated by the acting port's busy
  assign setB = aWrite && (aAddr == BOX_B) && !aBusy;
  assign setA = bWrite && (bAddr == BOX_A) && !bBusy;
  assign clrB = bRead  && (bAddr == BOX_B) && !bBusy;
  assign clrA = aRead  && (aAddr == BOX_A) && !aBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aFlag <= 1'b0;
      bFlag <= 1'b0;
    end else begin
      if (setA)      aFlag <= 1'b1;
      else if (clrA) aFlag <= 1'b0;
      if (setB)      bFlag <= 1'b1;
      else if (clrB) bFlag <= 1'b0;
    end
  end

  assert_set_b_R5: assert property (@(posedge clk) disable iff (!rstN)
    (aCe && aWe && aUpper && aAddr == BOX_B && !aBusy) |=> bFlag);
  assert_set_a_R5: assert property (@(posedge clk) disable iff (!rstN)
    (bCe && bWe && bLower && bAddr == BOX_A && !bBusy) |=> aFlag);
  assert_busy_hold_b_R8: assert property (@(posedge clk) disable iff (!rstN)
    (bBusy && bFlag) |=> bFlag);
  assert_busy_hold_a_R8: assert property (@(posedge clk) disable iff (!rstN)
    (aBusy && aFlag) |=> aFlag);
  assert_peek_b_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!bCe && bFlag) |=> bFlag);
  assert_peek_a_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!aCe && aFlag) |=> aFlag);
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [WORD_W-1:0] aWrData,
  input  logic [WORD_W-1:0] bWrData,
  output logic [WORD_W-1:0] aRdData,
  output logic [WORD_W-1:0] bRdData
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANE_N; l++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] aQ, bQ;

    // port A is applied last, so it wins a same-lane collision
    always_ff @(posedge clk) begin
      if (strobes.bWr[l]) laneMem[bAddr] <= bWrData[l*LANE_W +: LANE_W];
      if (strobes.aWr[l]) laneMem[aAddr] <= aWrData[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        aQ <= '0;
        bQ <= '0;
      end else begin
        aQ <= strobes.aRd[l] ? laneMem[aAddr] : '0;
        bQ <= strobes.bRd[l] ? laneMem[bAddr] : '0;
      end
    end

    assign aRdData[l*LANE_W +: LANE_W] = aQ;
    assign bRdData[l*LANE_W +: LANE_W] = bQ;

    assert_lane_zero_a_R3: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.aRd[l] |=> (aRdData[l*LANE_W +: LANE_W] == '0));
    assert_lane_zero_b_R3: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.bRd[l] |=> (bRdData[l*LANE_W +: LANE_W] == '0));
  end
endmodule

// File: rtl/xport_mailbox_ram.sv
module xport_mailbox_ram
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aCe,
  input  logic              aWe,
  input  logic              aOe,
  input  logic              aUpper,
  input  logic              aLower,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [15:0]       aWrData,
  input  logic              aBusy,
  output logic [15:0]       aRdData,
  output logic              aIrqN,
  input  logic              bCe,
  input  logic              bWe,
  input  logic              bOe,
  input  logic              bUpper,
  input  logic              bLower,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [15:0]       bWrData,
  input  logic              bBusy,
  output logic [15:0]       bRdData,
  output logic              bIrqN
);
  strobes_t strobes;
  logic aFlag, bFlag;

  mbx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .aCe(aCe), .aWe(aWe), .aOe(aOe), .aUpper(aUpper), .aLower(aLower),
    .aAddr(aAddr), .aBusy(aBusy),
    .bCe(bCe), .bWe(bWe), .bOe(bOe), .bUpper(bUpper), .bLower(bLower),
    .bAddr(bAddr), .bBusy(bBusy),
    .strobes(strobes), .aFlag(aFlag), .bFlag(bFlag)
  );

  mbx_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .aAddr(aAddr), .bAddr(bAddr),
    .aWrData(aWrData), .bWrData(bWrData),
    .aRdData(aRdData), .bRdData(bRdData)
  );

  assign aIrqN = ~aFlag;
  assign bIrqN = ~bFlag;

  assert_irq_reset_R1: assert property (@(posedge clk)
    !rstN |=> (aIrqN && bIrqN));
endmodule

// File: tb/tb_xport_mailbox_ram.sv
module tb_xport_mailbox_ram;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] BOXB = AW'(DEPTH - 1);
  localparam logic [AW-1:0] BOXA = AW'(DEPTH - 2);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aCe = 0, aWe = 0, aOe = 0, aUpper = 0, aLower = 0, aBusy = 0;
  logic bCe = 0, bWe = 0, bOe = 0, bUpper = 0, bLower = 0, bBusy = 0;
  logic [AW-1:0] aAddr = '0, bAddr = '0;
  logic [15:0] aWrData = '0, bWrData = '0;
  logic [15:0] aRdData, bRdData;
  logic aIrqN, bIrqN;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [DEPTH];

  always #2 clk = ~clk;

  xport_mailbox_ram #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN),
    .aCe(aCe), .aWe(aWe), .aOe(aOe), .aUpper(aUpper), .aLower(aLower),
    .aAddr(aAddr), .aWrData(aWrData), .aBusy(aBusy),
    .aRdData(aRdData), .aIrqN(aIrqN),
    .bCe(bCe), .bWe(bWe), .bOe(bOe), .bUpper(bUpper), .bLower(bLower),
    .bAddr(bAddr), .bWrData(bWrData), .bBusy(bBusy),
    .bRdData(bRdData), .bIrqN(bIrqN)
  );

  function automatic logic [15:0] laneMask(input logic [1:0] ln);
    return {{8{ln[1]}}, {8{ln[0]}}};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic setA(input logic ce, input logic we, input logic oe, input logic [1:0] ln,
                      input logic [AW-1:0] ad, input logic [15:0] d, input logic bz);
    aCe = ce; aWe = we; aOe = oe; aUpper = ln[1]; aLower = ln[0];
    aAddr = ad; aWrData = d; aBusy = bz;
  endtask

  task automatic setB(input logic ce, input logic we, input logic oe, input logic [1:0] ln,
                      input logic [AW-1:0] ad, input logic [15:0] d, input logic bz);
    bCe = ce; bWe = we; bOe = oe; bUpper = ln[1]; bLower = ln[0];
    bAddr = ad; bWrData = d; bBusy = bz;
  endtask

  task automatic idle();
    setA(0, 0, 0, 2'b00, '0, '0, 0);
    setB(0, 0, 0, 2'b00, '0, '0, 0);
  endtask

  task automatic readB(input logic [AW-1:0] ad, input logic [1:0] ln, input logic bz);
    setB(1, 0, 1, ln, ad, '0, bz);
    tick();
    setB(0, 0, 0, 2'b00, '0, '0, 0);
  endtask

  task automatic readA(input logic [AW-1:0] ad, input logic [1:0] ln, input logic bz);
    setA(1, 0, 1, ln, ad, '0, bz);
    tick();
    setA(0, 0, 0, 2'b00, '0, '0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    idle();
    repeat (3) tick();
    // R1: reset state
    chk("R1 aIrqN", {15'd0, aIrqN}, 16'd1);
    chk("R1 bIrqN", {15'd0, bIrqN}, 16'd1);
    chk("R1 aRdData", aRdData, 16'h0);
    chk("R1 bRdData", bRdData, 16'h0);
    rstN = 1'b1;
    tick();

    // R2: fill all words from A, busy high so no mailbox is raised (R8)
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 16'(i * 16'h1357) ^ 16'hA5C3;
      setA(1, 1, 0, 2'b11, AW'(i), model[i], 1);
      tick();
    end
    idle();
    tick();
    chk("R8 busy write leaves bIrqN high", {15'd0, bIrqN}, 16'd1);

    // R2/R3: read back every word from B with both lanes
    for (int i = 0; i < DEPTH; i++) begin
      readB(AW'(i), 2'b11, 0);
      chk("R2 full word readback", bRdData, model[i]);
      tick();
      chk("R3 data zero after non-read", bRdData, 16'h0);
    end

    // R3/R4: every lane combination on every address from A
    for (int i = 0; i < DEPTH; i++) begin
      for (int ln = 0; ln < 4; ln++) begin
        readA(AW'(i), 2'(ln), 1);
        chk("R3 lane masked read", aRdData, model[i] & laneMask(2'(ln)));
      end
    end

    // R2: single-lane writes
    setA(1, 1, 0, 2'b10, 4'd3, 16'hBEEF, 1); tick(); idle();
    model[3] = {8'hBE, model[3][7:0]};
    setB(1, 1, 0, 2'b01, 4'd4, 16'hCAFE, 0); tick(); idle();
    model[4] = {model[4][15:8], 8'hFE};
    readB(4'd3, 2'b11, 0); chk("R2 upper lane write", bRdData, model[3]);
    readA(4'd4, 2'b11, 0); chk("R2 lower lane write", aRdData, model[4]);

    // R4: chip enable low, selects low, output enable low
    setA(0, 1, 0, 2'b11, 4'd5, 16'h0000, 0); tick(); idle();
    setB(1, 1, 0, 2'b00, 4'd5, 16'hFFFF, 0); tick(); idle();
    readB(4'd5, 2'b11, 0); chk("R4 no write without access", bRdData, model[5]);
    setA(0, 0, 1, 2'b11, 4'd5, '0, 0); tick(); idle();
    chk("R4 ce low read zero", aRdData, 16'h0);
    setA(1, 0, 0, 2'b11, 4'd5, '0, 0); tick(); idle();
    chk("R3 oe low read zero", aRdData, 16'h0);

    // B mailbox sequence
    setA(1, 1, 0, 2'b11, BOXB, 16'h1234, 0); tick(); idle();
    model[BOXB] = 16'h1234;
    chk("R5 A write sets bIrqN low", {15'd0, bIrqN}, 16'd0);
    readA(BOXB, 2'b11, 0);
    chk("R11 mailbox readable by A", aRdData, 16'h1234);
    chk("R7 peek keeps bIrqN low", {15'd0, bIrqN}, 16'd0);
    readB(BOXB, 2'b11, 1);
    chk("R8 busy read keeps bIrqN low", {15'd0, bIrqN}, 16'd0);
    chk("R8 busy read still returns data", bRdData, 16'h1234);
    readB(BOXB, 2'b11, 0);
    chk("R6 owner read clears bIrqN", {15'd0, bIrqN}, 16'd1);
    chk("R11 owner reads message", bRdData, 16'h1234);

    // A mailbox sequence
    setB(1, 1, 0, 2'b11, BOXA, 16'h7777, 1); tick(); idle();
    chk("R8 busy write leaves aIrqN high", {15'd0, aIrqN}, 16'd1);
    readA(BOXA, 2'b11, 0);
    chk("R8 busy write still stores", aRdData, 16'h7777);
    setB(1, 1, 0, 2'b11, BOXA, 16'h4321, 0); tick(); idle();
    chk("R5 B write sets aIrqN low", {15'd0, aIrqN}, 16'd0);
    chk("R5 B write to A box leaves bIrqN", {15'd0, bIrqN}, 16'd1);
    readB(BOXA, 2'b11, 0);
    chk("R7 peek keeps aIrqN low", {15'd0, aIrqN}, 16'd0);
    readA(BOXA, 2'b11, 1);
    chk("R8 busy read keeps aIrqN low", {15'd0, aIrqN}, 16'd0);
    readA(BOXA, 2'b11, 0);
    chk("R6 owner read clears aIrqN", {15'd0, aIrqN}, 16'd1);
    chk("R11 A reads message", aRdData, 16'h4321);

    // R9: set and clear in the same cycle
    setA(1, 1, 0, 2'b11, BOXB, 16'h0055, 0); tick(); idle();
    setA(1, 1, 0, 2'b11, BOXB, 16'h0066, 0);
    setB(1, 0, 1, 2'b11, BOXB, '0, 0);
    tick(); idle();
    chk("R9 set wins over clear", {15'd0, bIrqN}, 16'd0);
    readB(BOXB, 2'b11, 0);
    chk("R9 later clear works", {15'd0, bIrqN}, 16'd1);
    chk("R9 last message stored", bRdData, 16'h0066);

    // R10: write collision and read-during-write
    setA(1, 1, 0, 2'b11, 4'd7, 16'hAAAA, 0);
    setB(1, 1, 0, 2'b11, 4'd7, 16'h5555, 0);
    tick(); idle();
    readB(4'd7, 2'b11, 0); chk("R10 port A wins collision", bRdData, 16'hAAAA);
    setA(1, 1, 0, 2'b11, 4'd8, 16'h0F0F, 0);
    setB(1, 0, 1, 2'b11, 4'd8, '0, 0);
    tick(); idle();
    chk("R10 read during write returns old", bRdData, model[8]);
    readB(4'd8, 2'b11, 0); chk("R10 new data after write", bRdData, 16'h0F0F);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule